// File: doc/BRIEF.md
# RF Front-End Mode Register Block

This block is a small register-mapped pin controller on a synchronous opcode bus. The bus has a load strobe, a fetch strobe, a 5-bit opcode and 8-bit write and read data. The block drives the control pins of an RF front end: a band/direction select line and its complement, a second switch line and its complement, a third switch line, active-high shutdown lines for the transmit and receive amplifiers, and an active-high mixer enable. It also drives two LEDs, a regulator enable and an 8-bit general-purpose port. Each pin of that port has its own output-enable.

In normal operation a 3-bit RF mode field picks one of a set of preset pin patterns. When the 2-bit debug field of the mode register is 01, the mode field is ignored. The RF pins then follow a raw pin register that software writes bit by bit. The raw register returns its two complement bits as the inverse of their partner bits, and writes to those bits have no effect. A push button and four strap inputs pass through a two-flop synchronizer and can then be read. Opcode 00000 returns a version constant in every case.

Top module: `rf_frontend_regs`

## Requirements
- R1: After reset, rdData is 0. All writable registers are zero: the mode register, the LED/regulator bits, the GPIO direction, the GPIO values and the raw RF register. Every GPIO pin is an input (gpioOe = 0), and the RF pins show the mode-000 pattern.
- R2: Opcode 00001 is the mode register. Bits 1:0 hold the debug field and bits 4:2 hold the RF mode. A read returns {000, mode, debug}. Bits 7:5 are reserved and always read 0.
- R3: When the debug field is anything other than 01, the RF pins follow a preset table. The pin order below is (bandSel, swA, swB, txAmpOff, rxAmpOff, mixerOn).
  - Modes 000, 110 and 111 (off): 0,0,0,1,1,0.
  - Mode 001 (bypass): 0,0,1,1,1,0.
  - Mode 010 (receive, low band): 1,0,0,1,0,1.
  - Mode 011 (receive, high band): 1,1,0,1,0,1.
  - Mode 100 (transmit, low band): 0,0,0,0,1,1.
  - Mode 101 (transmit, high band): 0,1,0,0,1,1.
  - The complement outputs are always the inverse of bandSel and swA.
- R4: With the debug field at 01, the RF mode is ignored and the RF pins follow opcode 00101. The bit assignment is: bit 7 is bandSel, bit 5 is swA, bit 3 is swB, bit 2 is txAmpOff, bit 1 is rxAmpOff and bit 0 is mixerOn. The complement pins are the inverse of bits 7 and 5.
- R5: A read of opcode 00101 returns bit 6 as the inverse of bit 7 and bit 4 as the inverse of bit 5, whatever was written to bits 6 and 4. The other bits read back as written.
- R6: In opcode 00010 only bits 2:0 are writable: bit 2 is the regulator enable and bits 1:0 drive the two LEDs. A read returns bit 7 as the button level and bits 6:3 as the four strap levels, each taken after two synchronizer flops, with bits 2:0 as written.
- R7: Opcode 00011 sets gpioOe, where 1 means output. Opcode 00100 sets gpioOut. A read of 00100 returns the levels on gpioIn.
- R8: A read of opcode 00000 returns the VERSION parameter. A read of any opcode from 00110 to 11111 returns 0. Loads to opcode 00000 or to any opcode from 00110 upward change no register and no pin.
- R9: A fetch without load updates rdData at the next clock edge. In every other cycle rdData holds its value. A load writes its register at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Write strobe |
| fetch | input | 1 | Read strobe |
| opcode | input | 5 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| btnIn | input | 1 | Push button level (0 while pressed) |
| strapIn | input | 4 | Strap input levels |
| gpioIn | input | 8 | GPIO pin levels |
| gpioOut | output | 8 | GPIO output values |
| gpioOe | output | 8 | GPIO output enables (1 = output) |
| ledOut | output | 2 | LED drives |
| regEnOut | output | 1 | Regulator enable |
| rfBandSel | output | 1 | RF band/direction select |
| rfBandSelN | output | 1 | Complement of rfBandSel |
| rfSwA | output | 1 | RF switch A |
| rfSwAN | output | 1 | Complement of rfSwA |
| rfSwB | output | 1 | RF switch B |
| txAmpOff | output | 1 | Transmit amplifier shutdown (1 = off) |
| rxAmpOff | output | 1 | Receive amplifier shutdown (1 = off) |
| mixerOn | output | 1 | Mixer enable (1 = on) |

## Verification
The assertions check, on every cycle, the bus timing rules:
- direction, value and LED/regulator registers take the loaded data one cycle later and otherwise stay still;
- rdData changes only after a fetch;
- a version read returns the constant;
- the complement pin pairs stay inverse.

The bench scenarios show the rest. They sweep every debug field against every RF mode, and every raw register value, which reveals the preset table, the debug override and the derived complement bits. They also sweep all button/strap combinations through the synchronizer, and load every unused opcode to show it has no effect.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam logic [4:0] OP_VERSION = 5'd0;
  localparam logic [4:0] OP_MODE    = 5'd1;
  localparam logic [4:0] OP_PINS    = 5'd2;
  localparam logic [4:0] OP_DIR     = 5'd3;
  localparam logic [4:0] OP_VAL     = 5'd4;
  localparam logic [4:0] OP_RAW     = 5'd5;
  localparam logic [1:0] DBG_RAW    = 2'b01;

  typedef struct packed {
    logic wrMode;
    logic wrPins;
    logic wrDir;
    logic wrVal;
    logic wrRaw;
    logic rdEn;
  } strobe_t;

  typedef struct packed {
    logic bandSel;
    logic swA;
    logic swB;
    logic txOff;
    logic rxOff;
    logic mixOn;
  } rfpins_t;
endpackage

// File: rtl/rfc_ctrl.sv
module rfc_ctrl
  import rfc_pkg::*;
(
  input  logic       load,
  input  logic       fetch,
  input  logic [4:0] opcode,
  output strobe_t    strobes
);
  always_comb begin
    strobes        = '0;
    strobes.wrMode = load && (opcode == OP_MODE);
    strobes.wrPins = load && (opcode == OP_PINS);
    strobes.wrDir  = load && (opcode == OP_DIR);
    strobes.wrVal  = load && (opcode == OP_VAL);
    strobes.wrRaw  = load && (opcode == OP_RAW);
    strobes.rdEn   = fetch && !load;
  end
endmodule

// File: rtl/rfc_preset.sv
module rfc_preset
  import rfc_pkg::*;
(
  input  logic [2:0] mode,
  output rfpins_t    pins
);
  // Field order: bandSel, swA, swB, txOff, rxOff, mixOn
  always_comb begin
    unique case (mode)
      3'b001:  pins = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      3'b010:  pins = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
      3'b011:  pins = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      3'b100:  pins = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      3'b101:  pins = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
      default: pins = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    endcase
  end
endmodule

// File: rtl/rfc_datapath.sv
module rfc_datapath
  import rfc_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned STRAP_W     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  VERSION     = 8'hA3
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [4:0]         opcode,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               btnIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic [DATA_W-1:0]  gpioIn,
  output logic [DATA_W-1:0]  gpioOut,
  output logic [DATA_W-1:0]  gpioOe,
  output logic [1:0]         ledOut,
  output logic               regEnOut,
  output rfpins_t            rfPins
);
  localparam int unsigned SYNC_W = STRAP_W + 1;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {STRAP_W{1'b0}}};

  logic [1:0]  dbgField;
  logic [2:0]  rfMode;
  logic [2:0]  pinBits;
  rfpins_t     rawPins;
  rfpins_t     presetPins;
  logic [SYNC_STAGES-1:0][SYNC_W-1:0] syncChain;
  logic [SYNC_W-1:0] syncOut;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dbgField <= '0;
      rfMode   <= '0;
      pinBits  <= '0;
      gpioOe   <= '0;
      gpioOut  <= '0;
      rawPins  <= '0;
    end else begin
      if (strobes.wrMode) begin
        dbgField <= wrData[1:0];
        rfMode   <= wrData[4:2];
      end
      if (strobes.wrPins) pinBits <= wrData[2:0];
      if (strobes.wrDir)  gpioOe  <= wrData;
      if (strobes.wrVal)  gpioOut <= wrData;
      if (strobes.wrRaw)
        rawPins <= '{wrData[7], wrData[5], wrData[3], wrData[2], wrData[1], wrData[0]};
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncChain[s] <= SYNC_RST;
        else if (s == 0) syncChain[s] <= {btnIn, strapIn};
        else syncChain[s] <= syncChain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate
  assign syncOut = syncChain[SYNC_STAGES-1];

  rfc_preset uPreset (.mode(rfMode), .pins(presetPins));

  assign rfPins   = (dbgField == DBG_RAW) ? rawPins : presetPins;
  assign ledOut   = pinBits[1:0];
  assign regEnOut = pinBits[2];

  always_comb begin
    rdNext = '0;
    unique case (opcode)
      OP_VERSION: rdNext = VERSION;
      OP_MODE:    rdNext = {3'b000, rfMode, dbgField};
      OP_PINS:    rdNext = {syncOut, pinBits};
      OP_DIR:     rdNext = gpioOe;
      OP_VAL:     rdNext = gpioIn;
      OP_RAW:     rdNext = {rawPins.bandSel, ~rawPins.bandSel, rawPins.swA, ~rawPins.swA,
                            rawPins.swB, rawPins.txOff, rawPins.rxOff, rawPins.mixOn};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdEn) rdData <= rdNext;
  end
endmodule

// File: rtl/rf_frontend_regs.sv
module rf_frontend_regs
  import rfc_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'hA3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic       fetch,
  input  logic [4:0] opcode,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       btnIn,
  input  logic [3:0] strapIn,
  input  logic [7:0] gpioIn,
  output logic [7:0] gpioOut,
  output logic [7:0] gpioOe,
  output logic [1:0] ledOut,
  output logic       regEnOut,
  output logic       rfBandSel,
  output logic       rfBandSelN,
  output logic       rfSwA,
  output logic       rfSwAN,
  output logic       rfSwB,
  output logic       txAmpOff,
  output logic       rxAmpOff,
  output logic       mixerOn
);
  strobe_t strobes;
  rfpins_t rfPins;

  rfc_ctrl uCtrl (.load(load), .fetch(fetch), .opcode(opcode), .strobes(strobes));

  rfc_datapath #(.DATA_W(8), .STRAP_W(4), .SYNC_STAGES(2), .VERSION(VERSION)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opcode(opcode), .wrData(wrData),
    .rdData(rdData), .btnIn(btnIn), .strapIn(strapIn), .gpioIn(gpioIn),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .ledOut(ledOut), .regEnOut(regEnOut),
    .rfPins(rfPins)
  );

  assign rfBandSel  = rfPins.bandSel;
  assign rfBandSelN = ~rfPins.bandSel;
  assign rfSwA      = rfPins.swA;
  assign rfSwAN     = ~rfPins.swA;
  assign rfSwB      = rfPins.swB;
  assign txAmpOff   = rfPins.txOff;
  assign rxAmpOff   = rfPins.rxOff;
  assign mixerOn    = rfPins.mixOn;
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter logic [7:0] VERSION = 8'hA3
) (
  input logic       clk,
  input logic       rstN,
  input logic       load,
  input logic       fetch,
  input logic [4:0] opcode,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic [7:0] gpioOut,
  input logic [7:0] gpioOe,
  input logic [1:0] ledOut,
  input logic       regEnOut,
  input logic       rfBandSel,
  input logic       rfBandSelN,
  input logic       rfSwA,
  input logic       rfSwAN
);
  assert_dir_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (load && opcode == 5'd3) |=> (gpioOe == $past(wrData)));

  assert_val_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    (load && opcode == 5'd4) |=> (gpioOut == $past(wrData)));

  assert_pins_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (load && opcode == 5'd2) |=> (ledOut == $past(wrData[1:0]) && regEnOut == $past(wrData[2])));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(gpioOe) && $stable(gpioOut) && $stable(ledOut) && $stable(regEnOut)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !fetch |=> $stable(rdData));

  assert_version_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fetch && !load && opcode == 5'd0) |=> (rdData == VERSION));

  always_comb begin
    if (rstN) begin
      assert_complement_R4: assert ((rfBandSelN == ~rfBandSel) && (rfSwAN == ~rfSwA));
    end
  end
endmodule

bind rf_frontend_regs rfc_checker #(.VERSION(VERSION)) uChk (
  .clk(clk), .rstN(rstN), .load(load), .fetch(fetch), .opcode(opcode),
  .wrData(wrData), .rdData(rdData), .gpioOut(gpioOut), .gpioOe(gpioOe),
  .ledOut(ledOut), .regEnOut(regEnOut), .rfBandSel(rfBandSel),
  .rfBandSelN(rfBandSelN), .rfSwA(rfSwA), .rfSwAN(rfSwAN)
);

// File: tb/tb_rf_frontend_regs.sv
module tb_rf_frontend_regs;
  localparam logic [7:0] VER = 8'hA3;

  logic clk = 0, rstN = 0, load = 0, fetch = 0, btnIn = 1;
  logic [4:0] opcode = 0;
  logic [7:0] wrData = 0, gpioIn = 0;
  logic [3:0] strapIn = 0;
  logic [7:0] rdData, gpioOut, gpioOe;
  logic [1:0] ledOut;
  logic regEnOut, rfBandSel, rfBandSelN, rfSwA, rfSwAN, rfSwB, txAmpOff, rxAmpOff, mixerOn;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rf_frontend_regs #(.VERSION(VER)) dut (.*);

  function automatic logic [7:0] pinsNow();
    return {rfBandSel, rfBandSelN, rfSwA, rfSwAN, rfSwB, txAmpOff, rxAmpOff, mixerOn};
  endfunction

  function automatic logic [7:0] expand(logic [5:0] p);
    return {p[5], ~p[5], p[4], ~p[4], p[3], p[2], p[1], p[0]};
  endfunction

  // R3 table, bit order bandSel, swA, swB, txOff, rxOff, mixOn
  function automatic logic [7:0] expPreset(logic [2:0] m);
    logic [5:0] p;
    case (m)
      3'd1: p = 6'b001110;
      3'd2: p = 6'b100101;
      3'd3: p = 6'b110101;
      3'd4: p = 6'b000011;
      3'd5: p = 6'b010011;
      default: p = 6'b000110;
    endcase
    return expand(p);
  endfunction

  function automatic logic [7:0] expRaw(logic [7:0] d);
    return expand({d[7], d[5], d[3], d[2], d[1], d[0]});
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] op, logic [7:0] d);
    @(negedge clk); load = 1; opcode = op; wrData = d;
    @(negedge clk); load = 0;
  endtask

  task automatic rd(logic [4:0] op, output logic [7:0] d);
    @(negedge clk); fetch = 1; opcode = op;
    @(negedge clk); fetch = 0;
    d = rdData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 8'h00);
    check("R1 gpioOe", gpioOe, 8'h00);
    check("R1 gpioOut", gpioOut, 8'h00);
    check("R1 led/reg", {5'b0, regEnOut, ledOut}, 8'h00);
    check("R1 rf pins", pinsNow(), expPreset(3'd0));
    rd(5'd1, r); check("R1 mode reg", r, 8'h00);
    rd(5'd5, r); check("R1 raw reg", r, expRaw(8'h00));

    // R8 version
    rd(5'd0, r); check("R8 version", r, VER);

    // R2/R3/R4 sweep of debug field and mode
    wr(5'd5, 8'h5A);
    for (int dbg = 0; dbg < 4; dbg++) begin
      for (int m = 0; m < 8; m++) begin
        wr(5'd1, {3'b101, m[2:0], dbg[1:0]});
        check(dbg == 1 ? "R4 debug pins" : "R3 preset pins", pinsNow(),
              dbg == 1 ? expRaw(8'h5A) : expPreset(m[2:0]));
        rd(5'd1, r); check("R2 mode readback", r, {3'b000, m[2:0], dbg[1:0]});
      end
    end

    // R4/R5 all raw values in debug mode
    wr(5'd1, 8'b000_011_01);
    for (int v = 0; v < 256; v++) begin
      wr(5'd5, v[7:0]);
      check("R4 raw pins", pinsNow(), expRaw(v[7:0]));
      rd(5'd5, r); check("R5 raw readback", r, expRaw(v[7:0]));
    end

    // R6 writable bits and synchronized inputs
    for (int v = 0; v < 8; v++) begin
      wr(5'd2, {5'b10101, v[2:0]});
      check("R6 led/reg", {5'b0, regEnOut, ledOut}, {5'b0, v[2:0]});
    end
    wr(5'd2, 8'h05);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk); btnIn = s[4]; strapIn = s[3:0];
      repeat (3) @(negedge clk);
      rd(5'd2, r); check("R6 button/strap read", r, {s[4:0], 3'b101});
    end

    // R7 GPIO
    for (int v = 0; v < 256; v += 17) begin
      wr(5'd3, v[7:0]); check("R7 dir", gpioOe, v[7:0]);
      rd(5'd3, r); check("R7 dir read", r, v[7:0]);
      wr(5'd4, ~v[7:0]); check("R7 val", gpioOut, ~v[7:0]);
      @(negedge clk); gpioIn = v[7:0] ^ 8'h3C;
      rd(5'd4, r); check("R7 level read", r, v[7:0] ^ 8'h3C);
    end

    // R8 loads to version/unused opcodes have no effect; unused reads 0
    wr(5'd3, 8'hC3); wr(5'd4, 8'h96); wr(5'd2, 8'h03);
    wr(5'd1, 8'b000_010_00); wr(5'd5, 8'hA5);
    for (int op = 0; op < 32; op++) begin
      if (op == 0 || op >= 6) begin
        wr(op[4:0], 8'hFF);
        check("R8 dir unchanged", gpioOe, 8'hC3);
        check("R8 val unchanged", gpioOut, 8'h96);
        check("R8 led unchanged", {5'b0, regEnOut, ledOut}, 8'h03);
        check("R8 rf unchanged", pinsNow(), expPreset(3'd2));
      end
    end
    rd(5'd1, r); check("R8 mode unchanged", r, 8'b000_010_00);
    rd(5'd5, r); check("R8 raw unchanged", r, expRaw(8'hA5));
    rd(5'd0, r); check("R8 version after writes", r, VER);
    for (int op = 6; op < 32; op++) begin
      rd(op[4:0], r); check("R8 unused read", r, 8'h00);
    end

    // R9 rdData holds without fetch, and during load
    rd(5'd0, r);
    @(negedge clk); opcode = 5'd3;
    repeat (3) @(negedge clk);
    check("R9 hold no fetch", rdData, VER);
    wr(5'd3, 8'h11);
    check("R9 hold on load", rdData, VER);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule